// File: doc/BRIEF.md
# H-Bridge Command Decoder with Fault Latch

This block sits between a controller and a two-side power output stage. Two direction pins each choose the level of their own half-bridge. That gives four drive patterns: forward, reverse, braking with both sides low and braking with both sides high. Two disable pins of opposite polarity can turn the whole bridge off. When the bridge is off, the open-drain fault line is pulled low.

Clean digital flags report a short circuit, overtemperature, undervoltage and a cooled-down condition. A short circuit or an overheat sets a latch that keeps both sides off, whatever the direction pins do. Only a release edge on one of the disable pins clears the latch, or a reset, which stands for a supply cycle. An overheat latch clears only once the die has cooled. Undervoltage blocks the outputs for as long as it lasts and latches nothing.

The four control pins pass through two-flop synchronisers. The fault flags are registered once. Outputs are decoded from this registered state, so a pin change shows at the outputs two clock edges later, and a fault flag shows one edge later.

Top module: `hb_cmd_guard`

## Requirements
- R1: With no disable, no latched fault and no undervoltage, `side_en_o` is 2'b11, `side_lvl_o[0]` equals `dir_a_i` and `side_lvl_o[1]` equals `dir_b_i`, and `flag_sink_o` is 0. This holds two clock edges after a pin change.
- R2: `off_req_i` high or `run_ok_i` low turns off both sides (`side_en_o` = 2'b00) and sets `flag_sink_o` to 1.
- R3: A `short_i` or `hot_i` flag seen at a clock edge latches both sides off and holds `flag_sink_o` at 1. This happens whatever the direction pins are, and the latch persists after the flag drops.
- R4: A latched fault clears on a falling edge of synchronised `off_req_i` or a rising edge of synchronised `run_ok_i`. After that the outputs follow the pins again and `flag_sink_o` returns to 0.
- R5: An overheat latch clears on such an edge only if `cool_i` is 1 at that edge. Otherwise the latch stays set.
- R6: A clearing edge that arrives while `short_i` is still 1 is ignored, and the latch stays set after `short_i` drops.
- R7: `uv_i` turns both sides off and sets `flag_sink_o` to 1 one edge later, with no latching. Once `uv_i` returns to 0, the outputs follow the pins again without any disable edge.
- R8: While `rst` is high both sides are off and `flag_sink_o` is 1. A reset clears any latched fault.
- R9: Whenever a side is not enabled, its `side_lvl_o` bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also models a supply cycle |
| dir_a_i | input | 1 | Level request for side 0 |
| dir_b_i | input | 1 | Level request for side 1 |
| off_req_i | input | 1 | Disable, active high |
| run_ok_i | input | 1 | Disable, active low |
| uv_i | input | 1 | Undervoltage flag |
| short_i | input | 1 | Short-circuit flag |
| hot_i | input | 1 | Overtemperature flag |
| cool_i | input | 1 | Die is below the trip point minus hysteresis |
| side_en_o | output | 2 | Per-side drive enable; 0 means the side is off (high impedance) |
| side_lvl_o | output | 2 | Per-side drive level |
| flag_sink_o | output | 1 | 1 pulls the fault line low; 0 leaves it undriven |

## Verification
The assertions check on every cycle that the two sides are always enabled together and that an idle side shows level 0. They also check that a short, overheat or undervoltage flag blocks the bridge one edge later, and that a disable pin held for three cycles blocks it. Only the bench scenarios can show the history-dependent behaviour. That covers the latch persisting after its flag drops, clearing on the correct disable edges, being refused while hot or while the short is still present, and undervoltage recovering with no edge at all.

// File: rtl/hb_cmd_pkg.sv
package hb_cmd_pkg;

    localparam int SIDES = 2;

    typedef enum logic [1:0] {
        LATCH_NONE  = 2'd0,
        LATCH_SHORT = 2'd1,
        LATCH_HOT   = 2'd2
    } latch_e;

    typedef struct packed {
        logic [SIDES-1:0] dir;
        logic             off_req;
        logic             run_ok;
    } ctl_t;

    typedef struct packed {
        logic [SIDES-1:0] en;
        logic [SIDES-1:0] lvl;
        logic             sink;
    } drv_t;

    localparam int   CTL_W    = $bits(ctl_t);
    localparam ctl_t CTL_SAFE = '{dir: '0, off_req: 1'b1, run_ok: 1'b0};

    function automatic logic pins_block(ctl_t c);
        return c.off_req | ~c.run_ok;
    endfunction

    function automatic logic release_edge(ctl_t prev, ctl_t now);
        return (prev.off_req & ~now.off_req) | (~prev.run_ok & now.run_ok);
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch
    import hb_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl_s,
    input  logic   short_i,
    input  logic   hot_i,
    input  logic   cool_i,
    output latch_e state_o
);
    ctl_t   ctl_prev;
    latch_e state_q;
    latch_e state_d;
    logic   rel;

    assign rel = release_edge(ctl_prev, ctl_s);

    always_comb begin
        state_d = state_q;
        if (short_i) begin
            state_d = LATCH_SHORT;
        end else if (hot_i) begin
            state_d = (state_q == LATCH_SHORT) ? LATCH_SHORT : LATCH_HOT;
        end else if (rel) begin
            if (state_q == LATCH_SHORT) state_d = LATCH_NONE;
            else if (state_q == LATCH_HOT && cool_i) state_d = LATCH_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LATCH_NONE;
            ctl_prev <= CTL_SAFE;
        end else begin
            state_q  <= state_d;
            ctl_prev <= ctl_s;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/hb_drive_decode.sv
module hb_drive_decode
    import hb_cmd_pkg::*;
(
    input  ctl_t   ctl_s,
    input  latch_e state_i,
    input  logic   uv_q,
    output drv_t   drv_o
);
    logic stop;

    assign stop = pins_block(ctl_s) | uv_q | (state_i != LATCH_NONE);

    genvar g;
    generate
        for (g = 0; g < SIDES; g++) begin : g_side
            assign drv_o.en[g]  = ~stop;
            assign drv_o.lvl[g] = ~stop & ctl_s.dir[g];
        end
    endgenerate

    assign drv_o.sink = stop;
endmodule

// File: rtl/hb_cmd_guard.sv
module hb_cmd_guard
    import hb_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_a_i,
    input  logic             dir_b_i,
    input  logic             off_req_i,
    input  logic             run_ok_i,
    input  logic             uv_i,
    input  logic             short_i,
    input  logic             hot_i,
    input  logic             cool_i,
    output logic [SIDES-1:0] side_en_o,
    output logic [SIDES-1:0] side_lvl_o,
    output logic             flag_sink_o
);
    ctl_t   ctl_raw;
    ctl_t   ctl_s;
    latch_e state;
    logic   uv_q;
    drv_t   drv;

    assign ctl_raw = '{dir: {dir_b_i, dir_a_i}, off_req: off_req_i, run_ok: run_ok_i};

    hb_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_SAFE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ctl_raw),
        .q_o (ctl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) uv_q <= 1'b0;
        else     uv_q <= uv_i;
    end

    hb_fault_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .ctl_s   (ctl_s),
        .short_i (short_i),
        .hot_i   (hot_i),
        .cool_i  (cool_i),
        .state_o (state)
    );

    hb_drive_decode u_dec (
        .ctl_s   (ctl_s),
        .state_i (state),
        .uv_q    (uv_q),
        .drv_o   (drv)
    );

    assign side_en_o   = drv.en;
    assign side_lvl_o  = drv.lvl;
    assign flag_sink_o = drv.sink;
endmodule

// File: rtl/hb_cmd_guard_chk.sv
module hb_cmd_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       off_req_i,
    input logic       run_ok_i,
    input logic       uv_i,
    input logic       short_i,
    input logic       hot_i,
    input logic [1:0] side_en_o,
    input logic [1:0] side_lvl_o,
    input logic       flag_sink_o
);
    a_r1_sides_together: assert property (@(posedge clk) disable iff (rst)
        side_en_o == 2'b00 || side_en_o == 2'b11);

    a_r1_sink_released: assert property (@(posedge clk) disable iff (rst)
        side_en_o == 2'b11 |-> !flag_sink_o);

    a_r2_off_req_held: assert property (@(posedge clk) disable iff (rst)
        off_req_i && $past(off_req_i) && $past(off_req_i, 2)
        |-> side_en_o == 2'b00 && flag_sink_o);

    a_r2_run_ok_low_held: assert property (@(posedge clk) disable iff (rst)
        !run_ok_i && !$past(run_ok_i) && !$past(run_ok_i, 2)
        |-> side_en_o == 2'b00 && flag_sink_o);

    a_r3_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(short_i) || $past(hot_i))
        |-> side_en_o == 2'b00 && flag_sink_o);

    a_r7_uv_blocks: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(uv_i) |-> side_en_o == 2'b00 && flag_sink_o);

    a_r9_idle_level_zero: assert property (@(posedge clk) disable iff (rst)
        side_en_o == 2'b00 |-> side_lvl_o == 2'b00);
endmodule

bind hb_cmd_guard hb_cmd_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .off_req_i   (off_req_i),
    .run_ok_i    (run_ok_i),
    .uv_i        (uv_i),
    .short_i     (short_i),
    .hot_i       (hot_i),
    .side_en_o   (side_en_o),
    .side_lvl_o  (side_lvl_o),
    .flag_sink_o (flag_sink_o)
);

// File: tb/test_hb_cmd_guard.sv
module test_hb_cmd_guard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_a_i = 1'b0, dir_b_i = 1'b0;
    logic       off_req_i = 1'b0, run_ok_i = 1'b1;
    logic       uv_i = 1'b0, short_i = 1'b0, hot_i = 1'b0, cool_i = 1'b1;
    logic [1:0] side_en_o, side_lvl_o;
    logic       flag_sink_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    hb_cmd_guard i_hb_cmd_guard (
        .clk (clk), .rst (rst),
        .dir_a_i (dir_a_i), .dir_b_i (dir_b_i),
        .off_req_i (off_req_i), .run_ok_i (run_ok_i),
        .uv_i (uv_i), .short_i (short_i), .hot_i (hot_i), .cool_i (cool_i),
        .side_en_o (side_en_o), .side_lvl_o (side_lvl_o), .flag_sink_o (flag_sink_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [1:0] en, input logic [1:0] lvl, input logic sink);
        n_checks++;
        if (side_en_o !== en || side_lvl_o !== lvl || flag_sink_o !== sink) begin
            n_fail++;
            $display("FAIL %s: got en=%b lvl=%b sink=%b, expected en=%b lvl=%b sink=%b",
                     tag, side_en_o, side_lvl_o, flag_sink_o, en, lvl, sink);
        end
    endtask

    task automatic t_reset;
        step(2);
        check("R8 reset state off", 2'b00, 2'b00, 1'b1);
        rst = 1'b0;
        step(3);
        check("R1 after reset follows pins", 2'b11, 2'b00, 1'b0);
    endtask

    task automatic t_dirs;
        for (int k = 0; k < 4; k++) begin
            dir_a_i = k[0];
            dir_b_i = k[1];
            step(3);
            check("R1 direction pattern", 2'b11, k[1:0], 1'b0);
        end
    endtask

    task automatic t_disable;
        dir_a_i = 1'b1; dir_b_i = 1'b1;
        off_req_i = 1'b1;
        step(3);
        check("R2 R9 off_req high", 2'b00, 2'b00, 1'b1);
        off_req_i = 1'b0;
        step(3);
        check("R2 off_req released", 2'b11, 2'b11, 1'b0);
        run_ok_i = 1'b0;
        step(3);
        check("R2 R9 run_ok low", 2'b00, 2'b00, 1'b1);
        run_ok_i = 1'b1;
        step(3);
        check("R2 run_ok released", 2'b11, 2'b11, 1'b0);
    endtask

    task automatic t_short;
        dir_a_i = 1'b1; dir_b_i = 1'b0;
        short_i = 1'b1;
        step(1);
        short_i = 1'b0;
        step(1);
        check("R3 short latches off", 2'b00, 2'b00, 1'b1);
        step(5);
        check("R3 latch persists", 2'b00, 2'b00, 1'b1);
        off_req_i = 1'b1;
        step(3);
        off_req_i = 1'b0;
        step(4);
        check("R4 off_req falling clears", 2'b11, 2'b01, 1'b0);
    endtask

    task automatic t_hot;
        dir_a_i = 1'b0; dir_b_i = 1'b1;
        cool_i = 1'b0;
        hot_i = 1'b1;
        step(1);
        hot_i = 1'b0;
        step(1);
        check("R3 overheat latches off", 2'b00, 2'b00, 1'b1);
        run_ok_i = 1'b0;
        step(3);
        run_ok_i = 1'b1;
        step(4);
        check("R5 clear refused while warm", 2'b00, 2'b00, 1'b1);
        cool_i = 1'b1;
        run_ok_i = 1'b0;
        step(3);
        run_ok_i = 1'b1;
        step(4);
        check("R4 R5 run_ok rising clears when cool", 2'b11, 2'b10, 1'b0);
    endtask

    task automatic t_edge_during_short;
        dir_a_i = 1'b1; dir_b_i = 1'b1;
        short_i = 1'b1;
        off_req_i = 1'b1;
        step(3);
        off_req_i = 1'b0;
        step(4);
        short_i = 1'b0;
        step(3);
        check("R6 edge during short ignored", 2'b00, 2'b00, 1'b1);
        off_req_i = 1'b1;
        step(3);
        off_req_i = 1'b0;
        step(4);
        check("R4 later edge clears", 2'b11, 2'b11, 1'b0);
    endtask

    task automatic t_uv;
        dir_a_i = 1'b0; dir_b_i = 1'b0;
        uv_i = 1'b1;
        step(2);
        check("R7 undervoltage off", 2'b00, 2'b00, 1'b1);
        uv_i = 1'b0;
        step(2);
        check("R7 undervoltage self recovery", 2'b11, 2'b00, 1'b0);
    endtask

    task automatic t_reset_clear;
        dir_a_i = 1'b1; dir_b_i = 1'b0;
        short_i = 1'b1;
        step(1);
        short_i = 1'b0;
        step(2);
        check("R3 latch before reset", 2'b00, 2'b00, 1'b1);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(3);
        check("R8 reset clears latch", 2'b11, 2'b01, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_dirs();
        t_disable();
        t_short();
        t_hot();
        t_edge_during_short();
        t_uv();
        t_reset_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule